// File: doc/BRIEF.md
# Per-Lane Vector Load Readiness Scoreboard

In a SIMT core a warp load is split into one scalar memory access per lane, and the load leaves the pipeline before any of them finish. This block keeps one pending bit for each lane of each vector register of each warp. When a warp load issues, the lanes named in its active mask are marked pending in the destination register. Lanes outside the mask are ready at once. Scalar responses come back in any order, each naming a warp, a register and a lane, and each clears its own bit. A register counts as usable only when none of its lanes is still pending.

Issue logic asks the block about a candidate instruction: up to two source registers, an optional destination register, and the instruction's active lane mask. The block answers with a single combinational stall bit. A source stalls the instruction when any lane that is active for that instruction is still pending. A destination stalls it when any lane at all is still pending, which prevents a write-after-write race with the earlier load. A response that arrives in the same cycle as the query already counts as returned. A response to a lane that is not pending is reported as an error and has no other effect.

Top module: `vls_lane_scoreboard`

## Requirements
- R1: After reset every lane of every register is ready, `q_stall` is 0 for any query, and `rsp_err` is 0.
- R2: A load with `ld_valid`=1 marks the lanes whose `ld_mask` bits are 1 as pending in register (`ld_warp`,`ld_reg`). Queries see this from the next cycle on.
- R3: Lanes whose `ld_mask` bit is 0 stay ready. A source query whose `q_mask` covers only such lanes does not stall.
- R4: With `q_valid`=1, `q_stall` is 1 when an enabled source (`q_src0_en`/`q_src0` or `q_src1_en`/`q_src1` of warp `q_warp`) has a pending lane whose `q_mask` bit is 1. Pending lanes whose `q_mask` bit is 0 do not stall.
- R5: A response (`rsp_valid`=1) to a pending lane clears that lane from the next cycle on. Lanes return in any order, and a register stalls until its last pending lane has returned.
- R6: A response to a pending lane counts as ready for a query in the same cycle (bypass).
- R7: With `q_dst_en`=1, `q_stall` is 1 when the destination register `q_dst` of warp `q_warp` has any pending lane, whatever `q_mask` holds.
- R8: A response to a lane that is not pending sets `rsp_err` to 1 in the next cycle and changes no pending bit. After a response to a pending lane, or a cycle with no response, `rsp_err` is 0 in the next cycle.
- R9: Pending state is kept separately per warp. A load to register r of one warp does not stall queries to register r of another warp.
- R10: `q_stall` is 0 when `q_valid` is 0. Operands whose enable bit is 0 are ignored.
- R11: A load and a response that hit the same lane of the same register in the same cycle leave that lane pending, because the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Warp load issues this cycle |
| ld_warp | input | 3 | Warp of the load |
| ld_reg | input | 4 | Destination register of the load |
| ld_mask | input | 32 | Active lanes of the load |
| rsp_valid | input | 1 | Scalar lane response this cycle |
| rsp_warp | input | 3 | Warp of the response |
| rsp_reg | input | 4 | Register of the response |
| rsp_lane | input | 5 | Lane of the response |
| rsp_err | output | 1 | Previous cycle's response hit a lane that was not pending |
| q_valid | input | 1 | Dependency query is present |
| q_warp | input | 3 | Warp of the queried instruction |
| q_src0_en | input | 1 | First source operand used |
| q_src0 | input | 4 | First source register |
| q_src1_en | input | 1 | Second source operand used |
| q_src1 | input | 4 | Second source register |
| q_dst_en | input | 1 | Destination operand used |
| q_dst | input | 4 | Destination register |
| q_mask | input | 32 | Active lanes of the queried instruction |
| q_stall | output | 1 | Queried instruction must not issue |

## Verification
`q_stall` is combinational. It depends on the registered pending bits and on the response presented in the same cycle. A load or a response therefore changes it one clock edge after it is presented, except for the same-cycle bypass. `rsp_err` is registered and refers to the response of the cycle before. The bench drives every input just after a falling edge and compares both outputs one nanosecond later, before the next rising edge. It compares `q_stall` against a bench model of the pending bits as they stood before that edge. It compares `rsp_err` against the error it predicted one step earlier. The bench updates its model only after both comparisons.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int unsigned DEF_WARPS = 8;
    localparam int unsigned DEF_REGS  = 16;
    localparam int unsigned DEF_LANES = 32;
    localparam int unsigned NUM_OPS   = 3;   // two sources, one destination

    // How an operand's pending lanes turn into a stall.
    typedef enum logic {
        OPK_SRC = 1'b0,   // only lanes active for the instruction matter
        OPK_DST = 1'b1    // any pending lane blocks (write-after-write)
    } opk_e;

endpackage

// File: rtl/vls_lane_onehot.sv
module vls_lane_onehot #(
    parameter int unsigned LANES  = vls_pkg::DEF_LANES,
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              en_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [LANES-1:0]  oh_o
);

    always_comb begin
        oh_o = '0;
        for (int l = 0; l < LANES; l++) begin
            oh_o[l] = en_i && (lane_i == LANE_W'(l));
        end
    end

endmodule

// File: rtl/vls_pend_array.sv
module vls_pend_array #(
    parameter int unsigned ENTRIES = vls_pkg::DEF_WARPS * vls_pkg::DEF_REGS,
    parameter int unsigned LANES   = vls_pkg::DEF_LANES,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_valid_i,
    input  logic [IDX_W-1:0]                ld_idx_i,
    input  logic [LANES-1:0]                ld_mask_i,
    input  logic [IDX_W-1:0]                rsp_idx_i,
    input  logic [LANES-1:0]                rsp_oh_i,   // zero when no response
    input  logic                            rsp_valid_i,
    output logic                            rsp_hit_o,
    output logic                            rsp_err_o,
    output logic [ENTRIES-1:0][LANES-1:0]   pend_o
);

    typedef struct packed {
        logic [ENTRIES-1:0][LANES-1:0] pend;
        logic                          rsp_err;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] rsp_row;

    always_comb begin
        rsp_row   = st_q.pend[rsp_idx_i];
        rsp_hit_o = |(rsp_row & rsp_oh_i);
    end

    always_comb begin
        logic [LANES-1:0] clr;
        logic [LANES-1:0] set;
        st_d         = st_q;
        st_d.rsp_err = rsp_valid_i && !rsp_hit_o;
        for (int e = 0; e < ENTRIES; e++) begin
            clr = (rsp_hit_o && (rsp_idx_i == IDX_W'(e))) ? rsp_oh_i : '0;
            set = (ld_valid_i && (ld_idx_i == IDX_W'(e))) ? ld_mask_i : '0;
            // a new load's set wins over a clear in the same cycle
            st_d.pend[e] = (st_q.pend[e] & ~clr) | set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o    = st_q.pend;
    assign rsp_err_o = st_q.rsp_err;

endmodule

// File: rtl/vls_operand_check.sv
module vls_operand_check #(
    parameter int unsigned   LANES = vls_pkg::DEF_LANES,
    parameter vls_pkg::opk_e KIND  = vls_pkg::OPK_SRC
) (
    input  logic             en_i,
    input  logic [LANES-1:0] row_i,   // registered pending lanes
    input  logic [LANES-1:0] byp_i,   // lanes returning this cycle
    input  logic [LANES-1:0] act_i,   // lanes active for the instruction
    output logic             busy_o
);

    logic [LANES-1:0] live;

    assign live = row_i & ~byp_i;

    generate
        if (KIND == vls_pkg::OPK_DST) begin : g_dst
            logic unused_act;
            assign unused_act = ^act_i;
            assign busy_o     = en_i && (|live);
        end else begin : g_src
            assign busy_o = en_i && (|(live & act_i));
        end
    endgenerate

endmodule

// File: rtl/vls_lane_scoreboard.sv
module vls_lane_scoreboard #(
    parameter int unsigned WARPS = vls_pkg::DEF_WARPS,
    parameter int unsigned REGS  = vls_pkg::DEF_REGS,
    parameter int unsigned LANES = vls_pkg::DEF_LANES,
    localparam int unsigned WARP_W  = (WARPS > 1) ? $clog2(WARPS) : 1,
    localparam int unsigned REG_W   = (REGS > 1) ? $clog2(REGS) : 1,
    localparam int unsigned LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned ENTRIES = WARPS * REGS,
    localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [WARP_W-1:0] ld_warp,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [LANES-1:0]  ld_mask,
    input  logic              rsp_valid,
    input  logic [WARP_W-1:0] rsp_warp,
    input  logic [REG_W-1:0]  rsp_reg,
    input  logic [LANE_W-1:0] rsp_lane,
    output logic              rsp_err,
    input  logic              q_valid,
    input  logic [WARP_W-1:0] q_warp,
    input  logic              q_src0_en,
    input  logic [REG_W-1:0]  q_src0,
    input  logic              q_src1_en,
    input  logic [REG_W-1:0]  q_src1,
    input  logic              q_dst_en,
    input  logic [REG_W-1:0]  q_dst,
    input  logic [LANES-1:0]  q_mask,
    output logic              q_stall
);

    import vls_pkg::*;

    function automatic logic [IDX_W-1:0] ent_idx(input logic [WARP_W-1:0] w,
                                                 input logic [REG_W-1:0]  r);
        return IDX_W'(w) * IDX_W'(REGS) + IDX_W'(r);
    endfunction

    logic [IDX_W-1:0]              ld_idx;
    logic [IDX_W-1:0]              rsp_idx;
    logic [LANES-1:0]              rsp_oh;
    logic                          rsp_hit;
    logic [ENTRIES-1:0][LANES-1:0] pend;

    logic [IDX_W-1:0]   op_idx [NUM_OPS];
    logic [NUM_OPS-1:0] op_en;
    logic [NUM_OPS-1:0] op_busy;

    always_comb begin
        ld_idx    = ent_idx(ld_warp, ld_reg);
        rsp_idx   = ent_idx(rsp_warp, rsp_reg);
        op_idx[0] = ent_idx(q_warp, q_src0);
        op_idx[1] = ent_idx(q_warp, q_src1);
        op_idx[2] = ent_idx(q_warp, q_dst);
        op_en     = {q_dst_en, q_src1_en, q_src0_en};
    end

    vls_lane_onehot #(.LANES(LANES)) u_rsp_dec (
        .en_i   (rsp_valid),
        .lane_i (rsp_lane),
        .oh_o   (rsp_oh)
    );

    vls_pend_array #(.ENTRIES(ENTRIES), .LANES(LANES)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid_i  (ld_valid),
        .ld_idx_i    (ld_idx),
        .ld_mask_i   (ld_mask),
        .rsp_idx_i   (rsp_idx),
        .rsp_oh_i    (rsp_oh),
        .rsp_valid_i (rsp_valid),
        .rsp_hit_o   (rsp_hit),
        .rsp_err_o   (rsp_err),
        .pend_o      (pend)
    );

    generate
        for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
            logic [LANES-1:0] byp;
            assign byp = (rsp_hit && (rsp_idx == op_idx[gi])) ? rsp_oh : '0;

            vls_operand_check #(
                .LANES (LANES),
                .KIND  ((gi == NUM_OPS - 1) ? OPK_DST : OPK_SRC)
            ) u_chk (
                .en_i   (op_en[gi]),
                .row_i  (pend[op_idx[gi]]),
                .byp_i  (byp),
                .act_i  (q_mask),
                .busy_o (op_busy[gi])
            );
        end
    endgenerate

    assign q_stall = q_valid && (|op_busy);

endmodule

// File: rtl/vls_lane_scoreboard_chk.sv
module vls_lane_scoreboard_chk #(
    parameter int unsigned WARP_W = 3,
    parameter int unsigned REG_W  = 4,
    parameter int unsigned LANES  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [WARP_W-1:0] ld_warp,
    input logic [REG_W-1:0]  ld_reg,
    input logic [LANES-1:0]  ld_mask,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              q_valid,
    input logic [WARP_W-1:0] q_warp,
    input logic              q_src0_en,
    input logic              q_src1_en,
    input logic              q_dst_en,
    input logic [REG_W-1:0]  q_dst,
    input logic              q_stall
);

    a_r10_no_query_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> !q_stall);

    a_r10_no_operand_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_src0_en && !q_src1_en && !q_dst_en) |-> !q_stall);

    a_r8_err_follows_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(rsp_valid && rst_n));

    a_r7_fresh_load_blocks_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_dst_en && !rsp_valid && $past(rst_n && ld_valid && (ld_mask != '0))
         && (q_warp == $past(ld_warp)) && (q_dst == $past(ld_reg))) |-> q_stall);

endmodule

bind vls_lane_scoreboard vls_lane_scoreboard_chk #(
    .WARP_W (WARP_W),
    .REG_W  (REG_W),
    .LANES  (LANES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_warp   (ld_warp),
    .ld_reg    (ld_reg),
    .ld_mask   (ld_mask),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .q_valid   (q_valid),
    .q_warp    (q_warp),
    .q_src0_en (q_src0_en),
    .q_src1_en (q_src1_en),
    .q_dst_en  (q_dst_en),
    .q_dst     (q_dst),
    .q_stall   (q_stall)
);

// File: tb/vls_lane_scoreboard_tb_top.sv
`timescale 1ns/1ps
module vls_lane_scoreboard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [2:0]  ld_warp;
    logic [3:0]  ld_reg;
    logic [31:0] ld_mask;
    logic        rsp_valid;
    logic [2:0]  rsp_warp;
    logic [3:0]  rsp_reg;
    logic [4:0]  rsp_lane;
    logic        rsp_err;
    logic        q_valid;
    logic [2:0]  q_warp;
    logic        q_src0_en;
    logic [3:0]  q_src0;
    logic        q_src1_en;
    logic [3:0]  q_src1;
    logic        q_dst_en;
    logic [3:0]  q_dst;
    logic [31:0] q_mask;
    logic        q_stall;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] mdl [8][16];
    logic        exp_err;

    always #2.5 clk = ~clk;

    vls_lane_scoreboard dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_warp(ld_warp), .ld_reg(ld_reg), .ld_mask(ld_mask),
        .rsp_valid(rsp_valid), .rsp_warp(rsp_warp), .rsp_reg(rsp_reg), .rsp_lane(rsp_lane),
        .rsp_err(rsp_err),
        .q_valid(q_valid), .q_warp(q_warp),
        .q_src0_en(q_src0_en), .q_src0(q_src0),
        .q_src1_en(q_src1_en), .q_src1(q_src1),
        .q_dst_en(q_dst_en), .q_dst(q_dst),
        .q_mask(q_mask), .q_stall(q_stall)
    );

    function automatic logic rsp_hits();
        return rsp_valid && mdl[rsp_warp][rsp_reg][rsp_lane];
    endfunction

    function automatic logic [31:0] live_row(input logic [3:0] r);
        logic [31:0] row;
        row = mdl[q_warp][r];
        if (rsp_hits() && rsp_warp == q_warp && rsp_reg == r)
            row[rsp_lane] = 1'b0;
        return row;
    endfunction

    function automatic logic exp_stall();
        logic s;
        s = 1'b0;
        if (q_valid) begin
            if (q_src0_en && (live_row(q_src0) & q_mask) != 0) s = 1'b1;
            if (q_src1_en && (live_row(q_src1) & q_mask) != 0) s = 1'b1;
            if (q_dst_en && live_row(q_dst) != 0) s = 1'b1;
        end
        return s;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_valid = 0; ld_warp = 0; ld_reg = 0; ld_mask = 0;
        rsp_valid = 0; rsp_warp = 0; rsp_reg = 0; rsp_lane = 0;
        q_valid = 0; q_warp = 0; q_src0_en = 0; q_src0 = 0;
        q_src1_en = 0; q_src1 = 0; q_dst_en = 0; q_dst = 0; q_mask = 0;
    endtask

    // Called right after a falling edge with inputs set; returns at the next falling edge.
    task automatic step(input string tag);
        logic hit;
        #1;
        check(tag, q_stall, exp_stall(), "q_stall");
        check(tag, rsp_err, exp_err, "rsp_err");
        hit     = rsp_hits();
        exp_err = rsp_valid && !hit;
        if (hit) mdl[rsp_warp][rsp_reg][rsp_lane] = 1'b0;
        if (ld_valid) mdl[ld_warp][ld_reg] = mdl[ld_warp][ld_reg] | ld_mask;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic query_src(input logic [2:0] w, input logic [3:0] r, input logic [31:0] m);
        q_valid = 1; q_warp = w; q_src0_en = 1; q_src0 = r; q_mask = m;
    endtask

    task automatic respond(input logic [2:0] w, input logic [3:0] r, input logic [4:0] l);
        rsp_valid = 1; rsp_warp = w; rsp_reg = r; rsp_lane = l;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < 8; w++)
            for (int r = 0; r < 16; r++)
                mdl[w][r] = '0;
        exp_err = 1'b0;
        idle_inputs();
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: everything ready after reset
        q_valid = 1; q_src0_en = 1; q_src1_en = 1; q_dst_en = 1;
        q_src0 = 4'd3; q_src1 = 4'd9; q_dst = 4'd15; q_mask = '1;
        step("R1");

        // R2: load lanes 4..7 of warp 0 reg 3
        ld_valid = 1; ld_warp = 0; ld_reg = 3; ld_mask = 32'h0000_00F0;
        query_src(0, 3, '1);           // same cycle: not yet visible
        step("R2");
        query_src(0, 3, 32'h0000_0010);
        step("R2");
        // R3: inactive lanes are ready
        query_src(0, 3, 32'hFFFF_FF0F);
        step("R3");
        // R4: pending lane outside query mask ignored, second source checked
        q_valid = 1; q_warp = 0; q_src1_en = 1; q_src1 = 3; q_mask = 32'h0000_0040;
        step("R4");
        // R5: out-of-order returns, still stalled until last
        respond(0, 3, 7); query_src(0, 3, '1); step("R5");
        respond(0, 3, 4); query_src(0, 3, '1); step("R5");
        respond(0, 3, 6); query_src(0, 3, '1); step("R5");
        // R6: last lane returns in the same cycle as the query
        respond(0, 3, 5); query_src(0, 3, '1); step("R6");
        query_src(0, 3, '1); step("R5");
        // R8: spurious response, then error visible, then clear
        respond(0, 3, 5); query_src(0, 3, '1); step("R8");
        query_src(0, 3, '1); step("R8");
        step("R8");

        // R9: warp isolation
        ld_valid = 1; ld_warp = 1; ld_reg = 3; ld_mask = 32'h8000_0001;
        step("R9");
        query_src(0, 3, '1); step("R9");
        query_src(1, 3, '1); step("R9");
        // R7: destination blocks whatever the mask
        q_valid = 1; q_warp = 1; q_dst_en = 1; q_dst = 3; q_mask = '0;
        step("R7");
        // R10: disabled operand and no-query cases
        q_valid = 1; q_warp = 1; q_src0_en = 0; q_src0 = 3; q_mask = '1;
        step("R10");
        q_valid = 0; q_warp = 1; q_src0_en = 1; q_src0 = 3; q_dst_en = 1; q_dst = 3; q_mask = '1;
        step("R10");
        // R11: load and response on the same lane together
        ld_valid = 1; ld_warp = 1; ld_reg = 3; ld_mask = 32'h0000_0001;
        respond(1, 3, 0);
        step("R11");
        query_src(1, 3, 32'h0000_0001); step("R11");
        respond(1, 3, 0); step("R11");
        respond(1, 3, 31); step("R11");
        query_src(1, 3, '1); step("R11");

        // random traffic over a small set of warps, registers and lanes
        for (int i = 0; i < 3000; i++) begin
            ld_valid = ($urandom % 4) == 0;
            ld_warp  = 3'($urandom % 2);
            ld_reg   = 4'($urandom % 4);
            ld_mask  = (($urandom % 8) == 0) ? $urandom : ($urandom & 32'h0000_00FF);
            rsp_valid = ($urandom % 3) != 0;
            rsp_warp  = 3'($urandom % 2);
            rsp_reg   = 4'($urandom % 4);
            rsp_lane  = 5'((($urandom % 8) == 0) ? ($urandom % 32) : ($urandom % 8));
            q_valid   = ($urandom % 8) != 0;
            q_warp    = 3'($urandom % 2);
            q_src0_en = $urandom % 2;
            q_src0    = 4'($urandom % 4);
            q_src1_en = $urandom % 2;
            q_src1    = 4'($urandom % 4);
            q_dst_en  = $urandom % 2;
            q_dst     = 4'($urandom % 4);
            q_mask    = $urandom & $urandom;
            step("R5");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule